// File: doc/BRIEF.md
# Multi-Input Tamper Event Controller

This block watches a small set of external tamper pins. For each pin it produces a one-cycle trigger pulse, a sticky detection flag and, where enabled, a one-cycle request to erase a bank of backup registers. Every pin has its own active polarity, mask bit, erase-inhibit bit and interrupt enable. One global two-bit filter field chooses the detection method. At 00 the block looks for an edge. At any other value it requires the pin to hold its active level for several sample ticks in a row.

Software reaches the block through a one-cycle write strobe and a combinational read port. The read port exposes a control word and a flag word. A flag on an unmasked pin blocks any further detection on that pin until software clears it. A flag on a masked pin is kept at zero by hardware, so every detection on that pin gives a trigger but never an erase. The erase request output drives the backup-register storage, which lives outside this block.

Top module: `tamper_event_ctrl`

## Requirements
- R1: After reset, the control word, the flag word, `trig_o`, `erase_req_o` and `irq_o` all read 0.
- R2: Address 0 holds the control word. Its fields are: polarity at bits [NCH-1:0], mask at bits [4+NCH-1:4], erase-inhibit at bits [8+NCH-1:8], interrupt enable at bits [12+NCH-1:12] and filter at bits [17:16]. All other bits read 0. Address 1 returns the flags in bits [NCH-1:0].
- R3: With filter 00, polarity 1 detects a rising edge of the pin and polarity 0 detects a falling edge. The opposite edge produces nothing.
- R4: With filter 01, 10 or 11, a detection occurs when the pin has been at its active level (high for polarity 1, low for polarity 0) for 2, 4 or 8 consecutive sample ticks. One tick occurs every TICK_DIV clocks. A shorter hold produces nothing, and one unbroken hold produces only one detection.
- R5: An accepted detection on an unmasked pin sets that pin's flag and drives a one-cycle pulse on `trig_o[i]`.
- R6: While a pin's flag is set, further detections on that pin are ignored: no trigger and no erase request.
- R7: Writing address 1 clears every flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R8: If a clear of a flag and a new detection on the same pin fall in the same cycle, the detection is accepted: a trigger fires and the flag stays set.
- R9: `erase_req_o` is a one-cycle pulse, issued in the same cycle as the trigger. It is the OR of the accepted unmasked detections whose erase-inhibit bit is 0.
- R10: On a masked pin, every detection still pulses `trig_o[i]`. Its flag is held at 0, and a flag already set is cleared the cycle after the mask is written. It never requests an erase, whatever its erase-inhibit bit says.
- R11: `irq_o[i]` is high exactly when the flag is set, the interrupt enable is 1 and the mask is 0.
- R12: In edge mode, `trig_o` rises on the third rising clock edge after the pin changes. Two edges are spent in the synchronizer and one in the flag register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tamper_i | input | NCH | Raw tamper pins, asynchronous |
| reg_wr_i | input | 1 | One-cycle write strobe |
| reg_addr_i | input | AW | Register address (0 control, 1 flags) |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data for `reg_addr_i`, combinational |
| trig_o | output | NCH | One-cycle trigger pulse per pin |
| erase_req_o | output | 1 | One-cycle backup-register erase request |
| irq_o | output | NCH | Per-pin interrupt level |

## Verification
The bench targets the cycle in which a software clear lands on top of a new detection. A design that lets the clear win would drop a real tamper event and leave the flag at zero. It drives each filter length with one hold that is one tick too short and one that is well over the limit. A counter that never saturates would then fire repeatedly, and an off-by-one limit would fire on the short hold. Masked pins get repeated edges and an erase-enabled setting. A design that lets a masked pin latch its flag would swallow the second trigger, or would leak an erase pulse. Two pins firing together, only one of them erase-enabled, expose an erase path that is not a plain OR.

// File: rtl/tamp_pkg.sv
package tamp_pkg;

  // filter field encodings
  typedef enum logic [1:0] {
    FLT_EDGE = 2'b00,
    FLT_L2   = 2'b01,
    FLT_L4   = 2'b10,
    FLT_L8   = 2'b11
  } flt_e;

  // control word field offsets
  localparam int unsigned POL_LSB  = 0;
  localparam int unsigned MSK_LSB  = 4;
  localparam int unsigned NOER_LSB = 8;
  localparam int unsigned IEN_LSB  = 12;
  localparam int unsigned FLT_LSB  = 16;
  localparam int unsigned MAX_CH   = 4;

  // register addresses
  localparam int unsigned CTRL_ADDR = 0;
  localparam int unsigned FLAG_ADDR = 1;

  // number of consecutive sample ticks a level must hold
  function automatic int unsigned hold_ticks(input logic [1:0] f);
    case (f)
      2'b01:   return 2;
      2'b10:   return 4;
      2'b11:   return 8;
      default: return 0;
    endcase
  endfunction

  // edge of the selected direction between two samples
  function automatic logic edge_hit(input logic pol, input logic cur, input logic prv);
    return pol ? (cur & ~prv) : (~cur & prv);
  endfunction

  // pin sits at its active level
  function automatic logic lvl_active(input logic pol, input logic cur);
    return ~(cur ^ pol);
  endfunction

endpackage

// File: rtl/tamp_sync.sv
module tamp_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= '0;
        else        st[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[g] <= '0;
        else        st[g] <= st[g-1];
      end
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/tamp_detect.sv
module tamp_detect
  import tamp_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       s_i,
  input  logic       tick_i,
  input  logic       pol_i,
  input  logic [1:0] filt_i,
  output logic       det_o
);

  logic             prv_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] need;
  logic [CNT_W-1:0] need_m1;
  logic             is_edge;
  logic             active;

  assign is_edge = (filt_i == FLT_EDGE);
  assign active  = lvl_active(pol_i, s_i);
  assign need    = CNT_W'(hold_ticks(filt_i));
  assign need_m1 = need - CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prv_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      prv_q <= s_i;
      if (is_edge || !active)           cnt_q <= '0;
      else if (tick_i && cnt_q < need)  cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // level detection fires once, on the tick that completes the hold
  assign det_o = is_edge ? edge_hit(pol_i, s_i, prv_q)
                         : (active && tick_i && (cnt_q == need_m1));

endmodule

// File: rtl/tamp_regs.sv
module tamp_regs
  import tamp_pkg::*;
#(
  parameter int unsigned NCH = 3,
  parameter int unsigned AW  = 2,
  parameter int unsigned DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [NCH-1:0] flag_i,
  output logic [DW-1:0]  rdata_o,
  output logic [NCH-1:0] pol_o,
  output logic [NCH-1:0] msk_o,
  output logic [NCH-1:0] noer_o,
  output logic [NCH-1:0] ien_o,
  output logic [1:0]     filt_o,
  output logic [NCH-1:0] clr_o
);

  localparam logic [DW-1:0] CH_ONES = DW'((64'd1 << NCH) - 64'd1);
  localparam logic [DW-1:0] CTRL_MASK = (CH_ONES << POL_LSB) | (CH_ONES << MSK_LSB)
                                      | (CH_ONES << NOER_LSB) | (CH_ONES << IEN_LSB)
                                      | (DW'(3) << FLT_LSB);

  logic [DW-1:0] ctrl_q;
  logic          sel_ctrl;
  logic          sel_flag;

  assign sel_ctrl = (addr_i == AW'(CTRL_ADDR));
  assign sel_flag = (addr_i == AW'(FLAG_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ctrl_q <= '0;
    else if (wr_i && sel_ctrl) ctrl_q <= wdata_i & CTRL_MASK;
  end

  assign pol_o  = ctrl_q[POL_LSB  +: NCH];
  assign msk_o  = ctrl_q[MSK_LSB  +: NCH];
  assign noer_o = ctrl_q[NOER_LSB +: NCH];
  assign ien_o  = ctrl_q[IEN_LSB  +: NCH];
  assign filt_o = ctrl_q[FLT_LSB  +: 2];

  assign clr_o = (wr_i && sel_flag) ? wdata_i[NCH-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl)      rdata_o = ctrl_q;
    else if (sel_flag) rdata_o[NCH-1:0] = flag_i;
  end

endmodule

// File: rtl/tamp_flags.sv
module tamp_flags #(
  parameter int unsigned NCH = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] det_i,
  input  logic [NCH-1:0] clr_i,
  input  logic [NCH-1:0] msk_i,
  input  logic [NCH-1:0] noer_i,
  output logic [NCH-1:0] flag_o,
  output logic [NCH-1:0] trig_o,
  output logic           erase_o,
  output logic [NCH-1:0] accept_o
);

  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] unm_acc;
  logic [NCH-1:0] flag_n;

  // a clear in the same cycle frees the flag, so the detection is taken
  assign accept_o = det_i & (~flag_q | clr_i);
  assign unm_acc  = accept_o & ~msk_i;
  assign flag_n   = (flag_q & ~clr_i & ~msk_i) | unm_acc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= '0;
      trig_o  <= '0;
      erase_o <= 1'b0;
    end else begin
      flag_q  <= flag_n;
      trig_o  <= accept_o;
      erase_o <= |(unm_acc & ~noer_i);
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/tamper_event_ctrl.sv
module tamper_event_ctrl
  import tamp_pkg::*;
#(
  parameter int unsigned NCH         = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TICK_DIV    = 4,
  parameter int unsigned AW          = 2,
  parameter int unsigned DW          = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tamper_i,
  input  logic           reg_wr_i,
  input  logic [AW-1:0]  reg_addr_i,
  input  logic [DW-1:0]  reg_wdata_i,
  output logic [DW-1:0]  reg_rdata_o,
  output logic [NCH-1:0] trig_o,
  output logic           erase_req_o,
  output logic [NCH-1:0] irq_o
);

  localparam int unsigned TW    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned CNT_W = 4;

  logic [NCH-1:0] sync_w;
  logic [NCH-1:0] det_vec;
  logic [NCH-1:0] acc_vec;
  logic [NCH-1:0] clr_vec;
  logic [NCH-1:0] flag_q;
  logic [NCH-1:0] pol_w;
  logic [NCH-1:0] msk_w;
  logic [NCH-1:0] noer_w;
  logic [NCH-1:0] ien_w;
  logic [1:0]     filt_w;
  logic [TW-1:0]  tick_cnt;
  logic           tick;

  // shared sample tick for level filtering
  assign tick = (tick_cnt == TW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tick_cnt <= '0;
    else if (tick) tick_cnt <= '0;
    else           tick_cnt <= tick_cnt + TW'(1);
  end

  tamp_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (tamper_i),
    .q     (sync_w)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tamp_detect #(.CNT_W(CNT_W)) u_det (
      .clk    (clk),
      .rst_n  (rst_n),
      .s_i    (sync_w[c]),
      .tick_i (tick),
      .pol_i  (pol_w[c]),
      .filt_i (filt_w),
      .det_o  (det_vec[c])
    );
  end

  tamp_regs #(.NCH(NCH), .AW(AW), .DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .flag_i  (flag_q),
    .rdata_o (reg_rdata_o),
    .pol_o   (pol_w),
    .msk_o   (msk_w),
    .noer_o  (noer_w),
    .ien_o   (ien_w),
    .filt_o  (filt_w),
    .clr_o   (clr_vec)
  );

  tamp_flags #(.NCH(NCH)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .det_i    (det_vec),
    .clr_i    (clr_vec),
    .msk_i    (msk_w),
    .noer_i   (noer_w),
    .flag_o   (flag_q),
    .trig_o   (trig_o),
    .erase_o  (erase_req_o),
    .accept_o (acc_vec)
  );

  // interrupt is never valid on a masked pin
  assign irq_o = flag_q & ien_w & ~msk_w;

endmodule

// File: rtl/tamp_chk.sv
module tamp_chk #(
  parameter int unsigned NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] trig,
  input logic           erase,
  input logic [NCH-1:0] flag,
  input logic [NCH-1:0] msk,
  input logic [NCH-1:0] det,
  input logic [NCH-1:0] clr
);

  AST_ERASE_WITH_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    erase |-> (trig != '0)); // R9

  AST_TRIG_FROM_DET: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != '0) |-> ((trig & ~$past(det)) == '0)); // R5

  AST_UNMASKED_TRIG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (trig != '0) |-> ((trig & ~$past(msk) & ~flag) == '0)); // R5

  AST_MASK_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (msk != '0) |=> ((flag & $past(msk)) == '0)); // R10

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag & ~clr & ~msk) != '0) |=>
      ((flag & $past(flag & ~clr & ~msk)) == $past(flag & ~clr & ~msk))); // R6

endmodule

bind tamper_event_ctrl tamp_chk #(.NCH(NCH)) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .trig  (trig_o),
  .erase (erase_req_o),
  .flag  (flag_q),
  .msk   (msk_w),
  .det   (det_vec),
  .clr   (clr_vec)
);

// File: tb/tamper_event_ctrl_tb_top.sv
`timescale 1ns/1ps
module tamper_event_ctrl_tb_top;

  localparam int NCH = 3;
  localparam int DIV = 4;
  localparam int AW  = 2;
  localparam int DW  = 32;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] tin = '0;
  logic           reg_wr = 1'b0;
  logic [AW-1:0]  reg_addr = '0;
  logic [DW-1:0]  reg_wdata = '0;
  logic [DW-1:0]  reg_rdata;
  logic [NCH-1:0] trig;
  logic           erase;
  logic [NCH-1:0] irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [NCH:0] exp_q [$];

  always #5 clk = ~clk;

  tamper_event_ctrl #(.NCH(NCH), .SYNC_STAGES(2), .TICK_DIV(DIV), .AW(AW), .DW(DW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tamper_i    (tin),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata),
    .trig_o      (trig),
    .erase_req_o (erase),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // control word per the documented layout
  function automatic logic [31:0] mk_ctrl(input logic [2:0] pol, input logic [2:0] msk,
                                          input logic [2:0] noer, input logic [2:0] ien,
                                          input logic [1:0] filt);
    return {14'd0, filt, 1'b0, ien, 1'b0, noer, 1'b0, msk, 1'b0, pol};
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side of the scoreboard
  task automatic expect_evt(input logic [NCH-1:0] t, input logic e);
    exp_q.push_back({e, t});
  endtask

  // monitor: every trigger cycle must match the next expected item
  always @(negedge clk) begin
    if (rst_n && ((trig != '0) || erase)) begin
      if (exp_q.size() == 0) begin
        chk("R6/R9 unexpected event", {28'd0, erase, trig}, 32'd0);
      end else begin
        logic [NCH:0] e;
        e = exp_q.pop_front();
        chk("R5/R9 trigger/erase", {28'd0, erase, trig}, {28'd0, e});
      end
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] cfg;
    idle(4);
    rst_n = 1'b1;
    // R1 reset state
    rd_chk("R1 ctrl", 0, 0);
    rd_chk("R1 flags", 1, 0);
    chk("R1 trig", {29'd0, trig}, 0);
    chk("R1 erase", {31'd0, erase}, 0);
    chk("R1 irq", {29'd0, irq}, 0);

    // R2 control layout; idle levels: ch0 low, ch1 high, ch2 low
    cfg = mk_ctrl(3'b101, 3'b000, 3'b010, 3'b111, 2'b00);
    wr(0, cfg | 32'hFFF0_8888);
    rd_chk("R2 ctrl readback", 0, cfg);
    @(negedge clk) tin[1] = 1'b1;
    idle(6);

    // R3 / R12 rising edge, polarity 1, erase enabled
    expect_evt(3'b001, 1'b1);
    @(negedge clk) tin[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R12 trig not before third edge", {29'd0, trig}, 0);
    @(negedge clk);
    chk("R12 trig on third edge", {29'd0, trig}, 32'b001);
    idle(3);
    rd_chk("R5 flag set", 1, 32'b001);
    chk("R11 irq follows flag", {29'd0, irq}, 32'b001);

    // R6 a new edge while flagged is ignored
    @(negedge clk) tin[0] = 1'b0;
    idle(4);
    @(negedge clk) tin[0] = 1'b1;
    idle(6);
    rd_chk("R6 flag held, no event", 1, 32'b001);

    // R7 clearing with 0 has no effect, with 1 clears
    wr(1, 32'd0);
    rd_chk("R7 zero write keeps flag", 1, 32'b001);
    wr(1, 32'b001);
    rd_chk("R7 flag cleared", 1, 0);
    chk("R11 irq drops", {29'd0, irq}, 0);

    // R3 wrong-direction edge
    @(negedge clk) tin[0] = 1'b0;
    idle(6);
    rd_chk("R3 falling edge ignored on polarity 1", 1, 0);

    // R3 / R9 falling edge polarity 0, erase inhibited
    expect_evt(3'b010, 1'b0);
    @(negedge clk) tin[1] = 1'b0;
    idle(6);
    rd_chk("R3 falling edge on polarity 0", 1, 32'b010);
    @(negedge clk) tin[1] = 1'b1;
    wr(1, 32'b010);
    idle(4);

    // R9 two pins together, only one erase-enabled
    expect_evt(3'b011, 1'b1);
    @(negedge clk) begin tin[0] = 1'b1; tin[1] = 1'b0; end
    idle(6);
    rd_chk("R9 both flags", 1, 32'b011);
    @(negedge clk) begin tin[0] = 1'b0; tin[1] = 1'b1; end
    wr(1, 32'b011);
    idle(4);

    // R8 clear coinciding with a new detection
    expect_evt(3'b001, 1'b1);
    @(negedge clk) tin[0] = 1'b1;
    idle(6);
    @(negedge clk) tin[0] = 1'b0;
    idle(4);
    expect_evt(3'b001, 1'b1);
    @(negedge clk) tin[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 1; reg_wdata = 32'b001;
    @(negedge clk) reg_wr = 1'b0;
    idle(4);
    rd_chk("R8 detection beats clear", 1, 32'b001);
    chk("R8 scoreboard drained", exp_q.size(), 0);

    // R10 masking an already-set flag clears it
    wr(0, mk_ctrl(3'b101, 3'b001, 3'b010, 3'b111, 2'b00));
    rd_chk("R10 mask clears flag", 1, 0);
    chk("R11 irq low when masked", {29'd0, irq}, 0);
    @(negedge clk) tin[0] = 1'b0;
    idle(4);

    // R10 masked pin: repeated triggers, no erase, no flag
    wr(0, mk_ctrl(3'b101, 3'b100, 3'b010, 3'b111, 2'b00));
    for (int k = 0; k < 2; k++) begin
      expect_evt(3'b100, 1'b0);
      @(negedge clk) tin[2] = 1'b1;
      idle(6);
      rd_chk("R10 masked flag stays 0", 1, 0);
      @(negedge clk) tin[2] = 1'b0;
      idle(4);
    end
    chk("R10 both masked triggers seen", exp_q.size(), 0);

    // R4 level filters, polarity 1 on pin 0
    for (int f = 1; f <= 3; f++) begin
      int need;
      need = 1 << f;
      wr(0, mk_ctrl(3'b101, 3'b100, 3'b010, 3'b111, f[1:0]));
      idle(4);
      @(negedge clk) tin[0] = 1'b1;
      idle((need - 1) * DIV - 1);
      @(negedge clk) tin[0] = 1'b0;
      idle(3 * DIV);
      rd_chk("R4 short hold ignored", 1, 0);
      expect_evt(3'b001, 1'b1);
      @(negedge clk) tin[0] = 1'b1;
      idle(3 * need * DIV);
      rd_chk("R4 long hold detected", 1, 32'b001);
      chk("R4 single detection per hold", exp_q.size(), 0);
      @(negedge clk) tin[0] = 1'b0;
      idle(4);
      wr(1, 32'b001);
      rd_chk("R7 level flag cleared", 1, 0);
    end

    // R4 level filter, polarity 0 on pin 1, erase inhibited
    wr(0, mk_ctrl(3'b101, 3'b100, 3'b010, 3'b111, 2'b01));
    idle(4);
    expect_evt(3'b010, 1'b0);
    @(negedge clk) tin[1] = 1'b0;
    idle(6 * DIV);
    rd_chk("R4 low level detected", 1, 32'b010);
    @(negedge clk) tin[1] = 1'b1;
    idle(4);
    chk("R4 scoreboard drained", exp_q.size(), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule